// File: doc/BRIEF.md
# Programmable AND/OR Logic Array Emulator

This block reproduces a fuse-programmed sum-of-products logic array in ordinary logic. It has sixteen inputs, eight outputs and forty-eight product terms. Each product term takes every input in its true form, its inverted form, or not at all. An OR plane picks which terms feed each output. A per-output polarity bit then either passes the OR result through or inverts it.

Configuration is written one fuse at a time through a small write port: a write strobe, an 11-bit fuse index and one data bit. The fuse image is held in flops, and a reset returns it to the unprogrammed image, in which every link is intact. Outputs are combinational from the inputs and the stored image. An enable input models the three-state output stage as a drive-enable vector plus data.

Fuse index layout (1928 fuses in total):
- Terms occupy indices 0 to 1535, 32 per term.
- Input `i` of term `t` uses index `32t+2i` for its true literal and `32t+2i+1` for its inverted literal.
- The OR links sit at `1536+8t+o`, for term `t` and output `o`.
- The polarity bits sit at `1920+o`.

A fuse value of 1 means the link is intact and 0 means it is blown.

Top module: `pla_emu`

## Requirements
- R1: After reset, with `en_i` high, every output reads 0 for any input pattern.
- R2: A product term with the true link of input i intact (fuse 32t+2i = 1) is 0 whenever input i is 0. With the inverted link intact (fuse 32t+2i+1 = 1) it is 0 whenever input i is 1. With both links blown, input i has no effect on the term.
- R3: A term that keeps both links of any one input intact is always 0. Such terms connected to an output never raise it.
- R4: Output o is the OR of the terms whose link 1536+8t+o is 1. Blowing that link (writing 0) removes term t from output o and from no other output.
- R5: The polarity fuse 1920+o set to 1 passes output o's OR result unchanged. Set to 0, it inverts that result.
- R6: With `en_i` low, `out_oe_o` is all zeros and `out_o` is all zeros. With `en_i` high, `out_oe_o` is all ones.
- R7: A write to a fuse index of 1928 or above changes no fuse and leaves the outputs unchanged.
- R8: A fuse write takes effect at the clock edge that samples `cfg_we_i`. Before that edge the outputs still reflect the old image. Without a write, the outputs follow the inputs with no clock.
- R9: Asserting `rst_ni` at any time restores the unprogrammed image, with all fuses 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for fuse writes |
| rst_ni | input | 1 | Active-low asynchronous reset to the unprogrammed image |
| cfg_we_i | input | 1 | Fuse write strobe |
| cfg_addr_i | input | 11 | Fuse index |
| cfg_data_i | input | 1 | Fuse value (1 intact, 0 blown) |
| en_i | input | 1 | Output enable (chip enable) |
| in_i | input | 16 | Array inputs |
| out_o | output | 8 | Output data, 0 while disabled |
| out_oe_o | output | 8 | Per-output drive enable |

## Verification
A wrong fuse in the stored image shows up at the ports only for those input patterns that the affected term or output depends on. The bench therefore sweeps table vectors and random vectors against a reference sum-of-products for the loaded map. A fuse write that lands on the wrong index, or one clock late, changes an output in the first cycle after the write edge. Directed checks sample just before and just after that edge. A reset that leaves any programmed link behind shows as a nonzero output on the first sample after reset.

// File: rtl/pla_pkg.sv
package pla_pkg;
  localparam int unsigned IN_N      = 16;
  localparam int unsigned OUT_N     = 8;
  localparam int unsigned TERM_N    = 48;
  localparam int unsigned LIT_N     = 2 * IN_N;
  localparam int unsigned AND_FUSES = TERM_N * LIT_N;
  localparam int unsigned OR_FUSES  = TERM_N * OUT_N;
  localparam int unsigned POL_FUSES = OUT_N;
  localparam int unsigned AND_BASE  = 0;
  localparam int unsigned OR_BASE   = AND_BASE + AND_FUSES;
  localparam int unsigned POL_BASE  = OR_BASE + OR_FUSES;
  localparam int unsigned FUSE_N    = POL_BASE + POL_FUSES;
  localparam int unsigned FUSE_AW   = $clog2(FUSE_N);
endpackage

// File: rtl/pla_fuse_store.sv
module pla_fuse_store
  import pla_pkg::*;
#(
  parameter int unsigned N  = FUSE_N,
  parameter int unsigned AW = FUSE_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic          data_i,
  output logic [N-1:0]  fuse_o
);
  logic [N-1:0] fuse_q;
  logic         hit;

  // out-of-range indices are dropped
  assign hit = we_i && (32'(addr_i) < N);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fuse_q <= '1;  // unprogrammed: every link intact
    else if (hit) fuse_q[addr_i] <= data_i;
  end

  assign fuse_o = fuse_q;
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int unsigned NI = IN_N,
  parameter int unsigned NT = TERM_N,
  localparam int unsigned LW = 2 * NI
) (
  input  logic [NI-1:0]    in_i,
  input  logic [NT*LW-1:0] fuse_i,
  output logic [NT-1:0]    term_o
);
  for (genvar t = 0; t < NT; t++) begin : g_term
    logic [NI-1:0] lit_ok;
    for (genvar i = 0; i < NI; i++) begin : g_lit
      logic f_true, f_comp;
      assign f_true    = fuse_i[t*LW + 2*i];
      assign f_comp    = fuse_i[t*LW + 2*i + 1];
      // intact true link needs 1, intact complement link needs 0
      assign lit_ok[i] = (in_i[i] | ~f_true) & (~in_i[i] | ~f_comp);
    end
    assign term_o[t] = &lit_ok;
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane
  import pla_pkg::*;
#(
  parameter int unsigned NT = TERM_N,
  parameter int unsigned NO = OUT_N
) (
  input  logic [NT-1:0]    term_i,
  input  logic [NT*NO-1:0] fuse_i,
  output logic [NO-1:0]    sum_o
);
  for (genvar o = 0; o < NO; o++) begin : g_out
    logic [NT-1:0] sel;
    for (genvar t = 0; t < NT; t++) begin : g_t
      assign sel[t] = term_i[t] & fuse_i[t*NO + o];
    end
    assign sum_o[o] = |sel;
  end
endmodule

// File: rtl/pla_out_stage.sv
module pla_out_stage
  import pla_pkg::*;
#(
  parameter int unsigned NO = OUT_N
) (
  input  logic [NO-1:0] sum_i,
  input  logic [NO-1:0] pol_i,
  input  logic          en_i,
  output logic [NO-1:0] out_o,
  output logic [NO-1:0] oe_o
);
  logic [NO-1:0] level;

  // pol=1 passes, pol=0 inverts
  assign level = sum_i ^ ~pol_i;
  assign oe_o  = {NO{en_i}};
  assign out_o = en_i ? level : '0;
endmodule

// File: rtl/pla_emu.sv
module pla_emu
  import pla_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [FUSE_AW-1:0] cfg_addr_i,
  input  logic               cfg_data_i,
  input  logic               en_i,
  input  logic [IN_N-1:0]    in_i,
  output logic [OUT_N-1:0]   out_o,
  output logic [OUT_N-1:0]   out_oe_o
);
  logic [FUSE_N-1:0] fuse;
  logic [TERM_N-1:0] term;
  logic [OUT_N-1:0]  sum;

  pla_fuse_store #(.N(FUSE_N), .AW(FUSE_AW)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_i),
    .data_i (cfg_data_i),
    .fuse_o (fuse)
  );

  pla_and_plane #(.NI(IN_N), .NT(TERM_N)) u_and (
    .in_i   (in_i),
    .fuse_i (fuse[AND_BASE +: AND_FUSES]),
    .term_o (term)
  );

  pla_or_plane #(.NT(TERM_N), .NO(OUT_N)) u_or (
    .term_i (term),
    .fuse_i (fuse[OR_BASE +: OR_FUSES]),
    .sum_o  (sum)
  );

  pla_out_stage #(.NO(OUT_N)) u_out (
    .sum_i (sum),
    .pol_i (fuse[POL_BASE +: POL_FUSES]),
    .en_i  (en_i),
    .out_o (out_o),
    .oe_o  (out_oe_o)
  );
endmodule

// File: rtl/pla_emu_chk.sv
module pla_emu_chk
  import pla_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_we_i,
  input logic [FUSE_AW-1:0] cfg_addr_i,
  input logic               cfg_data_i,
  input logic               en_i,
  input logic [IN_N-1:0]    in_i,
  input logic [OUT_N-1:0]   out_o,
  input logic [OUT_N-1:0]   out_oe_o
);
  logic no_eff_wr;
  assign no_eff_wr = !cfg_we_i || (32'(cfg_addr_i) >= FUSE_N);

  a_r6_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (out_oe_o == '0 && out_o == '0));

  a_r6_enabled_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (out_oe_o == '1));

  a_r6_data_within_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_o & ~out_oe_o) == '0);

  // R7 / R8: no effective write and steady inputs keep outputs steady
  a_r7_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_eff_wr |=> (!$stable(in_i) || !$stable(en_i) || $stable(out_o)));

  a_r8_comb_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(out_oe_o) || !$stable(en_i));
endmodule

bind pla_emu pla_emu_chk u_chk (.*);

// File: tb/pla_emu_tb.sv
module pla_emu_tb;
  import pla_pkg::*;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               cfg_we_i = 1'b0;
  logic [FUSE_AW-1:0] cfg_addr_i = '0;
  logic               cfg_data_i = 1'b0;
  logic               en_i = 1'b1;
  logic [IN_N-1:0]    in_i = '0;
  logic [OUT_N-1:0]   out_o, out_oe_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  pla_emu u_dut (.*);

  // stimulus / expected table for the loaded map
  typedef struct packed { logic [15:0] vin; logic [7:0] vexp; } vec_t;
  localparam vec_t TAB [8] = '{
    '{16'h0000, 8'h88}, '{16'h0001, 8'h89}, '{16'h0003, 8'h88},
    '{16'h0004, 8'h8B}, '{16'hC000, 8'h0C}, '{16'h4000, 8'h88},
    '{16'hFFFF, 8'h0F}, '{16'hC001, 8'h0D}
  };

  // reference for the loaded map
  function automatic logic [7:0] ref_out(input logic [15:0] v);
    logic [7:0] r;
    logic t0, t1, t2;
    t0 = v[0] & ~v[1];
    t1 = v[2];
    t2 = v[15] & v[14];
    r = '0;
    r[0] = t0 | t1;
    r[1] = t1;
    r[2] = t2;
    r[3] = 1'b1;       // no live term, polarity inverted
    r[7] = ~t2;        // term2, polarity inverted
    return r;
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = FUSE_AW'(a); cfg_data_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic prog_term(input int t, input logic [15:0] tm,
                           input logic [15:0] cm, input logic [7:0] om);
    for (int i = 0; i < 16; i++) begin
      wr(32*t + 2*i, tm[i]);
      wr(32*t + 2*i + 1, cm[i]);
    end
    for (int o = 0; o < 8; o++) wr(1536 + 8*t + o, om[o]);
  endtask

  task automatic apply(input logic [15:0] v);
    @(negedge clk_i);
    in_i = v;
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: blank image drives all zero
    apply(16'h0000); chk("R1 blank", out_o, 8'h00);
    apply(16'hFFFF); chk("R1 blank", out_o, 8'h00);
    apply(16'h5A5A); chk("R1 blank", out_o, 8'h00);
    chk("R6 oe on", out_oe_o, 8'hFF);

    // load map: R2/R4/R5
    prog_term(0, 16'h0001, 16'h0002, 8'h01);
    prog_term(1, 16'h0004, 16'h0000, 8'h03);
    prog_term(2, 16'hC000, 16'h0000, 8'h84);
    wr(1920 + 3, 1'b0);
    wr(1920 + 7, 1'b0);

    // table walk: R2 R3 R4 R5
    foreach (TAB[k]) begin
      apply(TAB[k].vin);
      chk("R2/R3/R4/R5 table", out_o, TAB[k].vexp);
    end
    for (int k = 0; k < 200; k++) begin
      logic [15:0] v;
      v = 16'($urandom);
      apply(v);
      chk("R2 random", out_o, ref_out(v));
    end

    // R8: write visible only after its edge
    apply(16'h0000);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = FUSE_AW'(1920 + 3); cfg_data_i = 1'b1;
    #1 chk("R8 before edge", out_o, 8'h88);
    @(posedge clk_i); #1;
    chk("R8 after edge / R5 passthrough", out_o, 8'h80);
    @(negedge clk_i); cfg_we_i = 1'b0;

    // R7: out of range write ignored
    wr(1928, 1'b0);
    wr(2047, 1'b0);
    apply(16'hC004); chk("R7 ignored", out_o, 8'h07);

    // R4: blow term1 -> out1 only
    wr(1536 + 8*1 + 1, 1'b0);
    apply(16'h0004); chk("R4 disconnect", out_o, 8'h81);

    // R6: disable
    @(negedge clk_i); en_i = 1'b0; #1;
    chk("R6 data off", out_o, 8'h00);
    chk("R6 oe off", out_oe_o, 8'h00);
    @(negedge clk_i); en_i = 1'b1; #1;
    chk("R6 restored", out_o, 8'h81);

    // R9: reset restores blank
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    apply(16'h0004); chk("R9 reset blank", out_o, 8'h00);
    apply(16'hC001); chk("R9 reset blank", out_o, 8'h00);

    done = 1'b1;
    finish_run();
  end
endmodule